// File: doc/BRIEF.md
# Microsequencer Return-Address Stack

This block keeps the return addresses of a microsequencer in a small last-in-first-out store. A call pushes the address of the next microinstruction. A return pops it. The current top entry sits on an output at all times, so the sequencer's address multiplexer can select it with no extra cycle. The stack holds DEPTH entries of AW bits each, 5 entries of 12 bits by default. A pointer from 0 to DEPTH counts the occupied entries, and 0 means empty.

Both ends saturate. A push when the stack is full replaces the topmost entry and leaves the pointer where it is. A pop when the stack is empty changes nothing. Push and pop are plain single-cycle strobes. They are not streams, because a sequencer cannot wait, so there is no back-pressure. The active-low full flag is a status pin that the sequencer may use to guard against calls nested too deeply. Every state change happens on the rising clock edge, and clear is synchronous.

Top module: `ustack_top`

## Requirements
- R1: On a rising edge with clear_i high, the pointer becomes 0 and full_n_o goes high, whatever push_i and pop_i are doing.
- R2: A push (push_i=1, pop_i=0) on a pointer below DEPTH increments the pointer. The address is written into the entry that the new pointer selects, so the first push fills entry 1.
- R3: full_n_o is low exactly when the pointer equals DEPTH, and high otherwise.
- R4: A push at pointer DEPTH leaves the pointer at DEPTH and replaces the top entry with the new address.
- R5: A pop (pop_i=1, push_i=0) on a non-zero pointer decrements the pointer. The top-of-stack output then shows the entry at the new pointer.
- R6: A pop at pointer 0 leaves the pointer at 0 and full_n_o high.
- R7: Successive pops return the pushed addresses in reverse order. This also holds after the stack has been emptied and filled again.
- R8: push_i and pop_i high together is a no-operation: the pointer and every entry stay as they are.
- R9: While the pointer is 0, tos_o reads all zeros. Otherwise tos_o equals the entry at the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_i | input | 1 | Synchronous clear of the pointer, highest priority |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| addr_i | input | AW | Return address to push |
| sp_o | output | $clog2(DEPTH+1) | Stack pointer, 0 means empty |
| tos_o | output | AW | Current top-of-stack entry |
| full_n_o | output | 1 | Low while the stack is full |

## Verification
A pointer that is off by one shows at the ports in the same cycle. sp_o and full_n_o read it directly, and tos_o shows a neighbouring entry. A corrupted entry can stay hidden until enough pops bring it to the top, possibly many cycles later. The bench therefore drains the stack fully and compares every value that comes out against a model. Saturation faults, such as wrapping past DEPTH or below 0, show within one cycle of the push or pop that crosses the boundary.

// File: rtl/ustack_pkg.sv
package ustack_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_PUSH  = 2'd1,
    OP_POP   = 2'd2,
    OP_CLEAR = 2'd3
  } stk_op_e;
endpackage

// File: rtl/ustack_ctrl.sv
module ustack_ctrl
  import ustack_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic          pop_i,
  output stk_op_e       op_o,
  output logic [PW-1:0] sp_o,
  output logic [PW-1:0] wr_idx_o,
  output logic          wr_en_o,
  output logic          full_n_o
);
  localparam logic [PW-1:0] TOP = PW'(DEPTH);

  logic [PW-1:0] sp_q;
  logic [PW-1:0] sp_d;
  logic          at_top, at_bot;
  logic          full_q;

  assign at_top = (sp_q == TOP);
  assign at_bot = (sp_q == '0);

  always_comb begin
    if (clear_i)              op_o = OP_CLEAR;
    else if (push_i && !pop_i) op_o = OP_PUSH;
    else if (pop_i && !push_i) op_o = OP_POP;
    else                       op_o = OP_HOLD;
  end

  always_comb begin
    sp_d     = sp_q;
    wr_en_o  = 1'b0;
    wr_idx_o = sp_q;
    unique case (op_o)
      OP_CLEAR: sp_d = '0;
      OP_PUSH: begin
        wr_en_o = 1'b1;
        if (!at_top) begin
          sp_d     = sp_q + 1'b1;
          wr_idx_o = sp_q + 1'b1;
        end
      end
      OP_POP:  if (!at_bot) sp_d = sp_q - 1'b1;
      default: sp_d = sp_q;
    endcase
  end

  always_ff @(posedge clk) begin
    sp_q   <= sp_d;
    full_q <= (sp_d == TOP);
  end

  assign sp_o     = sp_q;
  assign full_n_o = ~full_q;

  assert_clear_R1: assert property (@(posedge clk) clear_i |=> (sp_o == '0 && full_n_o));
  assert_full_flag_R3: assert property (@(posedge clk) disable iff (clear_i) 1'b1 |=> (full_n_o == (sp_o != TOP)));
  assert_push_inc_R2: assert property (@(posedge clk) disable iff (clear_i)
    (op_o == OP_PUSH && !at_top) |=> sp_o == $past(sp_o) + 1'b1);
  assert_push_sat_R4: assert property (@(posedge clk) disable iff (clear_i)
    (op_o == OP_PUSH && at_top) |=> sp_o == TOP);
  assert_pop_dec_R5: assert property (@(posedge clk) disable iff (clear_i)
    (op_o == OP_POP && !at_bot) |=> sp_o == $past(sp_o) - 1'b1);
  assert_pop_empty_R6: assert property (@(posedge clk) disable iff (clear_i)
    (op_o == OP_POP && at_bot) |=> (sp_o == '0 && full_n_o));
  assert_both_hold_R8: assert property (@(posedge clk) disable iff (clear_i)
    (push_i && pop_i) |=> $stable(sp_o));
  assert_range_R3: assert property (@(posedge clk) disable iff (clear_i) 1'b1 |=> sp_o <= TOP);
endmodule

// File: rtl/ustack_regs.sv
module ustack_regs #(
  parameter int DEPTH = 5,
  parameter int AW    = 12,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_data_o
);
  logic [AW-1:0] ent_q [1:DEPTH];
  logic [AW-1:0] rd_mux [0:DEPTH];

  assign rd_mux[0] = '0;

  for (genvar g = 1; g <= DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_en_i && wr_idx_i == PW'(g)) ent_q[g] <= wr_data_i;
    end
    assign rd_mux[g] = (rd_idx_i == PW'(g)) ? ent_q[g] : rd_mux[g-1];
  end

  assign rd_data_o = rd_mux[DEPTH];

  assert_wr_slot_R2: assert property (@(posedge clk)
    wr_en_i |-> (wr_idx_i != '0 && wr_idx_i <= PW'(DEPTH)));
endmodule

// File: rtl/ustack_top.sv
module ustack_top
  import ustack_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int AW    = 12,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] addr_i,
  output logic [PW-1:0] sp_o,
  output logic [AW-1:0] tos_o,
  output logic          full_n_o
);
  stk_op_e       op;
  logic [PW-1:0] wr_idx;
  logic          wr_en;

  ustack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .clear_i(clear_i), .push_i(push_i), .pop_i(pop_i),
    .op_o(op), .sp_o(sp_o), .wr_idx_o(wr_idx), .wr_en_o(wr_en),
    .full_n_o(full_n_o)
  );

  ustack_regs #(.DEPTH(DEPTH), .AW(AW)) u_regs (
    .clk(clk), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(addr_i),
    .rd_idx_i(sp_o), .rd_data_o(tos_o)
  );

  assert_empty_zero_R9: assert property (@(posedge clk) disable iff (clear_i)
    1'b1 |=> ((sp_o == '0) -> (tos_o == '0)));
  assert_push_visible_R2: assert property (@(posedge clk) disable iff (clear_i)
    (op == OP_PUSH) |=> tos_o == $past(addr_i));
endmodule

// File: tb/tb_ustack_top.sv
module tb_ustack_top;
  localparam int DEPTH = 5;
  localparam int AW    = 12;
  localparam int PW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic clear_i = 1'b0, push_i = 1'b0, pop_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [PW-1:0] sp_o;
  logic [AW-1:0] tos_o;
  logic full_n_o;

  int checks = 0, fails = 0;
  int m_sp = 0;
  logic [AW-1:0] m_ent [1:DEPTH];

  always #10 clk = ~clk;

  ustack_top #(.DEPTH(DEPTH), .AW(AW)) dut (
    .clk(clk), .clear_i(clear_i), .push_i(push_i), .pop_i(pop_i),
    .addr_i(addr_i), .sp_o(sp_o), .tos_o(tos_o), .full_n_o(full_n_o)
  );

  function automatic logic [AW-1:0] exp_tos();
    return (m_sp == 0) ? '0 : m_ent[m_sp];
  endfunction

  task automatic model(input logic c, input logic pu, input logic po, input logic [AW-1:0] a);
    if (c) m_sp = 0;
    else if (pu && !po) begin
      if (m_sp < DEPTH) m_sp++;
      m_ent[m_sp] = a;
    end else if (po && !pu) begin
      if (m_sp > 0) m_sp--;
    end
  endtask

  task automatic step(input logic c, input logic pu, input logic po, input logic [AW-1:0] a);
    clear_i = c; push_i = pu; pop_i = po; addr_i = a;
    @(posedge clk);
    model(c, pu, po, a);
    #5;
    clear_i = 0; push_i = 0; pop_i = 0;
  endtask

  task automatic check(input string req);
    checks++;
    if (sp_o != PW'(m_sp)) begin
      fails++; $display("FAIL %s sp actual=%0d expected=%0d", req, sp_o, m_sp);
    end
    checks++;
    if (full_n_o != (m_sp != DEPTH)) begin
      fails++; $display("FAIL %s full_n actual=%0b expected=%0b", req, full_n_o, m_sp != DEPTH);
    end
    checks++;
    if (tos_o !== exp_tos()) begin
      fails++; $display("FAIL %s tos actual=%h expected=%h", req, tos_o, exp_tos());
    end
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    step(1, 0, 0, 0); check("R1 reset");
    for (int i = 1; i <= DEPTH; i++) begin
      step(0, 1, 0, AW'(i * 3 + 1)); check(i == DEPTH ? "R3 full" : "R2 push");
    end
    step(0, 1, 0, 12'hABC); check("R4 push when full");
    step(0, 1, 1, 12'h555); check("R8 push+pop hold");
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 0, 1, 0); check("R5 R7 pop order");
    end
    step(0, 0, 1, 0); check("R6 pop when empty");
    step(0, 0, 1, 0); check("R9 empty tos zero");
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 1, 0, AW'(12'hF00 + i)); check("R7 refill");
    end
    step(1, 1, 1, 12'h777); check("R1 clear priority");
    for (int i = 0; i < 2000; i++) begin
      int r = $urandom_range(0, 99);
      logic c = (r < 3);
      logic pu = (r >= 3 && r < 55) || (r >= 92);
      logic po = (r >= 50);
      step(c, pu, po, AW'($urandom)); check("R7 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule